// File: doc/BRIEF.md
# DMA Channel Address and Count Register Set with Self-Reload

This block keeps the register state of one DMA channel. There are two address registers, base and working, and two count registers, base and working. It also holds a request mask bit and two mode bits. One mode bit turns on self-reload and the other selects address decrement. A CPU load puts one value into a base register and its working partner in the same clock. After that, the base copy changes only on another CPU load.

Each transfer the channel completes arrives as a `step` pulse. A step moves the working address by one in the selected direction and lowers the working count by one. When a step finds a count of 0000h, the count wraps to FFFFh. That wrap is the channel's own end of process, and it raises `tc` for one cycle. An end of process can also come from outside on `ext_eop`. Either kind of end of process does one of two things:

- With self-reload on, both working registers are copied back from the base registers and the mask is left alone. The channel can then serve a new request with no CPU action.
- With self-reload off, the mask is set, which blocks further requests.

Top module: `dmaar_channel`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) clears all four address and count registers, both mode bits, `tc` and `req_out`, and sets the mask (`masked` = 1).
- R2: `ld_addr` writes `ld_addr_data` into both the base and the working address at the next edge. `ld_cnt` does the same for `ld_cnt_data` into both count registers.
- R3: The base address and base count change only through a CPU load. Steps, end of process, reloads and mask or mode writes leave them unchanged.
- R4: A step raises the working address by one when `dec_on` = 0 and lowers it by one when `dec_on` = 1. The address wraps modulo 2^AW, so FFFFh+1 gives 0000h and 0000h-1 gives FFFFh.
- R5: A step lowers the working count by one. A step taken at count 0000h is an underflow: the count goes to FFFFh (when no reload applies) and `tc` is high for exactly the one following cycle.
- R6: With self-reload on (`autoinit_on` = 1), an underflow reloads the working address and count from the base registers at the same edge, and the mask keeps its value.
- R7: With self-reload off, an underflow sets the mask. The working registers keep their stepped values, which puts the count at FFFFh.
- R8: A high `ext_eop` causes the same reload or mask-set as an underflow, and this takes precedence over a step in the same cycle. It never raises `tc`.
- R9: `mask_wr` loads `mask_val` into the mask. `req_out` is registered and equals `dreq` AND NOT `masked` as seen at the previous edge.
- R10: A CPU load in the same cycle as a step or an end of process wins for the register it targets.
- R11: A mask-set caused by an end of process wins over a `mask_wr` that clears the mask in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ld_addr | input | 1 | Load base and working address |
| ld_addr_data | input | AW | Address load value |
| ld_cnt | input | 1 | Load base and working count |
| ld_cnt_data | input | CW | Count load value |
| mode_wr | input | 1 | Write the two mode bits |
| mode_autoinit | input | 1 | Self-reload enable value for `mode_wr` |
| mode_dec | input | 1 | Address-decrement value for `mode_wr` |
| mask_wr | input | 1 | Write the mask bit |
| mask_val | input | 1 | Mask value for `mask_wr` |
| dreq | input | 1 | Raw service request |
| step | input | 1 | One transfer completed |
| ext_eop | input | 1 | External end of process |
| cur_addr | output | AW | Working address |
| cur_cnt | output | CW | Working count |
| base_addr | output | AW | Base address |
| base_cnt | output | CW | Base count |
| tc | output | 1 | One-cycle terminal-count pulse |
| masked | output | 1 | Mask bit |
| req_out | output | 1 | Registered, unmasked request |
| autoinit_on | output | 1 | Self-reload mode bit |
| dec_on | output | 1 | Address-decrement mode bit |

## Verification
The bench builds the block with its default widths, AW = CW = 16. With 16-bit registers, the exact 0000h-to-FFFFh count underflow can be driven directly. So can address wrap in both directions: FFFFh up to 0000h and 0000h down to FFFFh. Small loaded counts bring underflow, reload and masking within a few steps. Directed cycles then cover loads colliding with steps, end of process colliding with mask writes, and the one-cycle lag of the request gate.

// File: rtl/dmaar_pkg.sv
package dmaar_pkg;

  typedef struct packed {
    logic autoinit;
    logic dec;
  } dmaar_mode_t;

  function automatic logic [63:0] dmaar_adv(input logic [63:0] v, input logic down);
    dmaar_adv = down ? v - 64'd1 : v + 64'd1;
  endfunction

endpackage

// File: rtl/dmaar_addr_path.sv
module dmaar_addr_path #(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ld,
  input  logic [AW-1:0] ld_data,
  input  logic          step,
  input  logic          dec,
  input  logic          reload,
  output logic [AW-1:0] cur_q,
  output logic [AW-1:0] base_q
);
  import dmaar_pkg::*;

  localparam int PADW = 64 - AW;

  logic [63:0]   wide_cur;
  logic [63:0]   wide_nxt;
  logic [AW-1:0] stepped;

  assign wide_cur = {{PADW{1'b0}}, cur_q};
  assign wide_nxt = dmaar_adv(wide_cur, dec);
  assign stepped  = wide_nxt[AW-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      cur_q  <= '0;
      base_q <= '0;
    end else if (ld) begin
      cur_q  <= ld_data;
      base_q <= ld_data;
    end else if (reload) begin
      cur_q  <= base_q;
    end else if (step) begin
      cur_q  <= stepped;
    end
  end

  a_r2_addr_load: assert property (@(posedge clk) disable iff (rst)
    ld |=> (cur_q == $past(ld_data)) && (base_q == $past(ld_data)));

  a_r3_addr_base_hold: assert property (@(posedge clk) disable iff (rst)
    !ld |=> $stable(base_q));

  a_r4_addr_inc: assert property (@(posedge clk) disable iff (rst)
    (step && !ld && !reload && !dec) |=> cur_q == $past(cur_q) + AW'(1));

  a_r4_addr_dec: assert property (@(posedge clk) disable iff (rst)
    (step && !ld && !reload && dec) |=> cur_q == $past(cur_q) - AW'(1));

  a_r6_addr_reload: assert property (@(posedge clk) disable iff (rst)
    (reload && !ld) |=> cur_q == $past(base_q));

endmodule

// File: rtl/dmaar_count_path.sv
module dmaar_count_path #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ld,
  input  logic [CW-1:0] ld_data,
  input  logic          step,
  input  logic          reload,
  output logic [CW-1:0] cur_q,
  output logic [CW-1:0] base_q,
  output logic          uflow,
  output logic          tc_q
);

  localparam logic [CW-1:0] ALL_ONES = {CW{1'b1}};

  assign uflow = step && !ld && (cur_q == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      cur_q  <= '0;
      base_q <= '0;
      tc_q   <= 1'b0;
    end else begin
      tc_q <= uflow;
      if (ld) begin
        cur_q  <= ld_data;
        base_q <= ld_data;
      end else if (reload) begin
        cur_q  <= base_q;
      end else if (step) begin
        cur_q  <= cur_q - CW'(1);
      end
    end
  end

  a_r2_cnt_load: assert property (@(posedge clk) disable iff (rst)
    ld |=> (cur_q == $past(ld_data)) && (base_q == $past(ld_data)));

  a_r3_cnt_base_hold: assert property (@(posedge clk) disable iff (rst)
    !ld |=> $stable(base_q));

  a_r5_wrap: assert property (@(posedge clk) disable iff (rst)
    (step && !ld && !reload && cur_q == '0) |=> cur_q == ALL_ONES);

  a_r5_tc_single: assert property (@(posedge clk) disable iff (rst)
    tc_q |=> !tc_q || $past(step));

  a_r6_cnt_reload: assert property (@(posedge clk) disable iff (rst)
    (reload && !ld) |=> cur_q == $past(base_q));

endmodule

// File: rtl/dmaar_ctrl.sv
module dmaar_ctrl (
  input  logic clk,
  input  logic rst,
  input  logic mode_wr,
  input  logic mode_autoinit,
  input  logic mode_dec,
  input  logic mask_wr,
  input  logic mask_val,
  input  logic dreq,
  input  logic eop_any,
  output logic reload,
  output logic masked_q,
  output logic req_q,
  output logic autoinit_q,
  output logic dec_q
);
  import dmaar_pkg::*;

  dmaar_mode_t mode_q;

  assign autoinit_q = mode_q.autoinit;
  assign dec_q      = mode_q.dec;
  assign reload     = eop_any && mode_q.autoinit;

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q   <= '0;
      masked_q <= 1'b1;
      req_q    <= 1'b0;
    end else begin
      req_q <= dreq && !masked_q;
      if (mode_wr) begin
        mode_q.autoinit <= mode_autoinit;
        mode_q.dec      <= mode_dec;
      end
      if (eop_any && !mode_q.autoinit) begin
        masked_q <= 1'b1;
      end else if (mask_wr) begin
        masked_q <= mask_val;
      end
    end
  end

  a_r7_mask_set: assert property (@(posedge clk) disable iff (rst)
    (eop_any && !autoinit_q) |=> masked_q);

  a_r6_mask_keep: assert property (@(posedge clk) disable iff (rst)
    (eop_any && autoinit_q && !mask_wr) |=> $stable(masked_q));

  a_r9_req_gate: assert property (@(posedge clk) disable iff (rst)
    masked_q |=> !req_q);

endmodule

// File: rtl/dmaar_channel.sv
module dmaar_channel #(
  parameter int AW = 16,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ld_addr,
  input  logic [AW-1:0] ld_addr_data,
  input  logic          ld_cnt,
  input  logic [CW-1:0] ld_cnt_data,
  input  logic          mode_wr,
  input  logic          mode_autoinit,
  input  logic          mode_dec,
  input  logic          mask_wr,
  input  logic          mask_val,
  input  logic          dreq,
  input  logic          step,
  input  logic          ext_eop,
  output logic [AW-1:0] cur_addr,
  output logic [CW-1:0] cur_cnt,
  output logic [AW-1:0] base_addr,
  output logic [CW-1:0] base_cnt,
  output logic          tc,
  output logic          masked,
  output logic          req_out,
  output logic          autoinit_on,
  output logic          dec_on
);

  logic uflow;
  logic eop_any;
  logic reload;

  assign eop_any = uflow || ext_eop;

  dmaar_ctrl u_ctrl (
    .clk           (clk),
    .rst           (rst),
    .mode_wr       (mode_wr),
    .mode_autoinit (mode_autoinit),
    .mode_dec      (mode_dec),
    .mask_wr       (mask_wr),
    .mask_val      (mask_val),
    .dreq          (dreq),
    .eop_any       (eop_any),
    .reload        (reload),
    .masked_q      (masked),
    .req_q         (req_out),
    .autoinit_q    (autoinit_on),
    .dec_q         (dec_on)
  );

  dmaar_addr_path #(.AW(AW)) u_addr (
    .clk     (clk),
    .rst     (rst),
    .ld      (ld_addr),
    .ld_data (ld_addr_data),
    .step    (step),
    .dec     (dec_on),
    .reload  (reload),
    .cur_q   (cur_addr),
    .base_q  (base_addr)
  );

  dmaar_count_path #(.CW(CW)) u_cnt (
    .clk     (clk),
    .rst     (rst),
    .ld      (ld_cnt),
    .ld_data (ld_cnt_data),
    .step    (step),
    .reload  (reload),
    .cur_q   (cur_cnt),
    .base_q  (base_cnt),
    .uflow   (uflow),
    .tc_q    (tc)
  );

  a_r8_ext_no_tc: assert property (@(posedge clk) disable iff (rst)
    (ext_eop && !step) |=> !tc);

  a_r1_reset_mask: assert property (@(posedge clk)
    rst |=> masked && !tc && !req_out);

endmodule

// File: tb/test_dmaar_channel.sv
module test_dmaar_channel;

  localparam int CLK_PERIOD = 10;
  localparam int AW = 16;
  localparam int CW = 16;
  localparam int NVEC = 24;

  localparam logic [3:0] OP_IDLE = 4'd0;
  localparam logic [3:0] OP_MODE = 4'd1;
  localparam logic [3:0] OP_MASK = 4'd2;
  localparam logic [3:0] OP_LDA  = 4'd3;
  localparam logic [3:0] OP_LDC  = 4'd4;
  localparam logic [3:0] OP_STEP = 4'd5;
  localparam logic [3:0] OP_EOP  = 4'd6;

  // {op, data, exp addr, exp count, exp mask, exp tc}
  localparam logic [53:0] VEC [NVEC] = '{
    {OP_MODE, 16'h0001, 16'h0000, 16'h0000, 1'b1, 1'b0},
    {OP_MASK, 16'h0000, 16'h0000, 16'h0000, 1'b0, 1'b0},
    {OP_LDA,  16'h1000, 16'h1000, 16'h0000, 1'b0, 1'b0},
    {OP_LDC,  16'h0002, 16'h1000, 16'h0002, 1'b0, 1'b0},
    {OP_STEP, 16'h0000, 16'h1001, 16'h0001, 1'b0, 1'b0},
    {OP_STEP, 16'h0000, 16'h1002, 16'h0000, 1'b0, 1'b0},
    {OP_STEP, 16'h0000, 16'h1000, 16'h0002, 1'b0, 1'b1},
    {OP_IDLE, 16'h0000, 16'h1000, 16'h0002, 1'b0, 1'b0},
    {OP_STEP, 16'h0000, 16'h1001, 16'h0001, 1'b0, 1'b0},
    {OP_EOP,  16'h0000, 16'h1000, 16'h0002, 1'b0, 1'b0},
    {OP_MODE, 16'h0002, 16'h1000, 16'h0002, 1'b0, 1'b0},
    {OP_STEP, 16'h0000, 16'h0FFF, 16'h0001, 1'b0, 1'b0},
    {OP_STEP, 16'h0000, 16'h0FFE, 16'h0000, 1'b0, 1'b0},
    {OP_STEP, 16'h0000, 16'h0FFD, 16'hFFFF, 1'b1, 1'b1},
    {OP_IDLE, 16'h0000, 16'h0FFD, 16'hFFFF, 1'b1, 1'b0},
    {OP_MASK, 16'h0000, 16'h0FFD, 16'hFFFF, 1'b0, 1'b0},
    {OP_LDA,  16'h0000, 16'h0000, 16'hFFFF, 1'b0, 1'b0},
    {OP_LDC,  16'h0001, 16'h0000, 16'h0001, 1'b0, 1'b0},
    {OP_STEP, 16'h0000, 16'hFFFF, 16'h0000, 1'b0, 1'b0},
    {OP_EOP,  16'h0000, 16'hFFFF, 16'h0000, 1'b1, 1'b0},
    {OP_MODE, 16'h0000, 16'hFFFF, 16'h0000, 1'b1, 1'b0},
    {OP_LDA,  16'hFFFF, 16'hFFFF, 16'h0000, 1'b1, 1'b0},
    {OP_STEP, 16'h0000, 16'h0000, 16'hFFFF, 1'b1, 1'b1},
    {OP_IDLE, 16'h0000, 16'h0000, 16'hFFFF, 1'b1, 1'b0}
  };

  logic          clk = 1'b0;
  logic          rst;
  logic          ld_addr, ld_cnt, mode_wr, mode_autoinit, mode_dec;
  logic          mask_wr, mask_val, dreq, step, ext_eop;
  logic [AW-1:0] ld_addr_data;
  logic [CW-1:0] ld_cnt_data;
  logic [AW-1:0] cur_addr, base_addr;
  logic [CW-1:0] cur_cnt, base_cnt;
  logic          tc, masked, req_out, autoinit_on, dec_on;

  int n_checks = 0;
  int n_fail   = 0;
  int cycles   = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dmaar_channel #(.AW(AW), .CW(CW)) i_dmaar_channel (
    .clk (clk), .rst (rst),
    .ld_addr (ld_addr), .ld_addr_data (ld_addr_data),
    .ld_cnt (ld_cnt), .ld_cnt_data (ld_cnt_data),
    .mode_wr (mode_wr), .mode_autoinit (mode_autoinit), .mode_dec (mode_dec),
    .mask_wr (mask_wr), .mask_val (mask_val), .dreq (dreq),
    .step (step), .ext_eop (ext_eop),
    .cur_addr (cur_addr), .cur_cnt (cur_cnt),
    .base_addr (base_addr), .base_cnt (base_cnt),
    .tc (tc), .masked (masked), .req_out (req_out),
    .autoinit_on (autoinit_on), .dec_on (dec_on)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic idle_inputs();
    ld_addr = 0; ld_cnt = 0; mode_wr = 0; mode_autoinit = 0; mode_dec = 0;
    mask_wr = 0; mask_val = 0; step = 0; ext_eop = 0;
    ld_addr_data = '0; ld_cnt_data = '0;
  endtask

  task automatic drive_op(input logic [3:0] op, input logic [15:0] d);
    idle_inputs();
    case (op)
      OP_MODE: begin mode_wr = 1; mode_autoinit = d[0]; mode_dec = d[1]; end
      OP_MASK: begin mask_wr = 1; mask_val = d[0]; end
      OP_LDA:  begin ld_addr = 1; ld_addr_data = d; end
      OP_LDC:  begin ld_cnt = 1; ld_cnt_data = d; end
      OP_STEP: step = 1;
      OP_EOP:  ext_eop = 1;
      default: ;
    endcase
  endtask

  task automatic tick();
    @(negedge clk);
    idle_inputs();
  endtask

  initial begin
    while (cycles < 20000) begin
      @(posedge clk);
      cycles++;
    end
    n_checks++;
    n_fail++;
    $display("FAIL watchdog expired actual=%0d expected=<20000", cycles);
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    idle_inputs();
    dreq = 0;
    rst = 1;
    repeat (3) @(negedge clk);
    rst = 0;
    // R1 reset state
    chk("R1 cur_addr", 32'(cur_addr), 0);
    chk("R1 cur_cnt", 32'(cur_cnt), 0);
    chk("R1 base_addr", 32'(base_addr), 0);
    chk("R1 base_cnt", 32'(base_cnt), 0);
    chk("R1 masked", 32'(masked), 1);
    chk("R1 tc", 32'(tc), 0);
    chk("R1 req_out", 32'(req_out), 0);
    chk("R1 mode", {30'd0, autoinit_on, dec_on}, 0);

    // Vector walk: R2 R4 R5 R6 R7 R8
    for (int i = 0; i < NVEC; i++) begin
      drive_op(VEC[i][53:50], VEC[i][49:34]);
      tick();
      chk($sformatf("R2/R4/R6/R7/R8 vec%0d addr", i), 32'(cur_addr), 32'(VEC[i][33:18]));
      chk($sformatf("R5/R6 vec%0d cnt", i), 32'(cur_cnt), 32'(VEC[i][17:2]));
      chk($sformatf("R7/R8 vec%0d mask", i), 32'(masked), 32'(VEC[i][1]));
      chk($sformatf("R5/R8 vec%0d tc", i), 32'(tc), 32'(VEC[i][0]));
    end

    // R3: bases unchanged by steps, wraps, eop
    chk("R3 base_addr", 32'(base_addr), 32'hFFFF);
    chk("R3 base_cnt", 32'(base_cnt), 32'h0001);

    // R10: load collides with step
    idle_inputs(); mask_wr = 1; mask_val = 0; tick();
    ld_addr = 1; ld_addr_data = 16'h2000; ld_cnt = 1; ld_cnt_data = 16'h0005; step = 1;
    tick();
    chk("R10 cur_addr", 32'(cur_addr), 32'h2000);
    chk("R10 base_addr", 32'(base_addr), 32'h2000);
    chk("R10 cur_cnt", 32'(cur_cnt), 32'h0005);
    chk("R10 tc", 32'(tc), 0);

    // R11: eop mask-set beats mask clear (self-reload off)
    ext_eop = 1; mask_wr = 1; mask_val = 0;
    tick();
    chk("R11 masked", 32'(masked), 1);

    // R9: request gating with one-cycle lag
    dreq = 1;
    tick();
    chk("R9 req while masked", 32'(req_out), 0);
    mask_wr = 1; mask_val = 0;
    tick();
    chk("R9 req lag", 32'(req_out), 0);
    tick();
    chk("R9 req unmasked", 32'(req_out), 1);
    dreq = 0;
    tick();
    chk("R9 req drop", 32'(req_out), 0);

    // R8: ext eop with step under self-reload -> reload wins, no tc
    mode_wr = 1; mode_autoinit = 1; tick();
    step = 1; tick();
    chk("R4 stepped addr", 32'(cur_addr), 32'h2001);
    step = 1; ext_eop = 1; tick();
    chk("R8 reload addr", 32'(cur_addr), 32'h2000);
    chk("R8 reload cnt", 32'(cur_cnt), 32'h0005);
    chk("R8 no tc", 32'(tc), 0);
    chk("R6 mask kept", 32'(masked), 0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule